// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Deferred Commit

This block drives four independent pulse-width outputs from one input clock. Each channel counts input-clock ticks across a programmable period and holds its output at the active level for a programmable number of ticks at the start of each period. The active level can be inverted per channel. Software reaches the block through a plain 32-bit register port: an address, a write strobe, write data, and combinational read data.

Software writes never touch the running waveform. They land in a shadow copy of every channel setting. A single global commit request, written to the global control word, arms all four channels together. Each armed channel copies its shadow settings at the end of its own current period, so a running waveform never shows a truncated or stretched pulse. A channel that is switched off takes the new settings on the next clock. The commit bit stays readable as set until the last channel has taken its copy.

Top module: `pwm_sync_bank`

## Requirements
- R1: After reset all outputs are low, the global word reads 0, every channel control word reads 0x101, and every period, duty and phase word reads 0.
- R2: Register map (byte offsets): global word at 0x00 with channel enables in bits 3..0 and commit request in bit 31; for channel n, control at 0x14+16n, period at 0x18+16n, phase at 0x1C+16n, duty at 0x20+16n. The control word keeps only bits 1..0 (mode), 3 (invert) and 8 (pop mask); other bits read 0. Period, duty and phase keep all 32 bits. Any other offset reads 0 and ignores writes.
- R3: Writes to enable, control, period and duty change no output until a commit request has been written and the channel has reached its commit point.
- R4: Writing 1 to bit 31 arms every channel; an enabled channel takes its shadow settings at the clock edge that ends its current period (counter at period-1), and a disabled channel takes them at the next clock edge.
- R5: Bit 31 of the global word reads 1 while any channel is still armed and 0 once all have taken their settings.
- R6: In mode 1 an enabled channel counts 0 to period-1 and, uninverted, is high while the count is below duty, giving exactly duty high cycles per period.
- R7: A duty at or above the period keeps the output continuously active; a duty of 0 keeps it continuously inactive.
- R8: Setting control bit 3 inverts the output, including the level a disabled channel drives.
- R9: A disabled channel holds its counter at zero and drives its inactive level; when enabled by a commit its first period starts with count 0 on the cycle after it takes the settings.
- R10: Phase words are read/write storage only and never alter an output.
- R11: A committed mode other than 1 drives the inactive level.
- R12: Channels commit independently, each at its own period boundary, from the one shared request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock; all counts are in its ticks |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 7 | Byte offset of the register accessed |
| we_i | input | 1 | Write strobe for the current address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| pwm_o | output | 4 | Channel outputs, bit n for channel n |

## Verification
The hardest situation to reach is a commit request arriving while three channels run with unrelated periods, so that each is at a different point of its period and the request stays pending across several staggered boundaries. The stimulus runs channels with periods 5, 8 and 13, issues new duties and a commit at an arbitrary moment, and reads the commit bit every cycle until it clears, while a behavioural model checks every output on every clock. Re-enabling a parked channel is also placed mid-run to show its first period starts from zero.

// File: rtl/pwm_sync_pkg.sv
package pwm_sync_pkg;
  localparam int unsigned NUM_CH_DEF = 4;
  localparam int unsigned AW_DEF     = 7;
  localparam int unsigned DW         = 32;

  localparam int unsigned GLB_OFS   = 'h00;
  localparam int unsigned CH_BASE   = 'h14;
  localparam int unsigned CH_STRIDE = 'h10;
  localparam int unsigned OFS_CTRL  = 'h0;
  localparam int unsigned OFS_RANGE = 'h4;
  localparam int unsigned OFS_PHASE = 'h8;
  localparam int unsigned OFS_DUTY  = 'hC;

  localparam int unsigned UPD_BIT = 31;
  localparam int unsigned POL_BIT = 3;
  localparam int unsigned POP_BIT = 8;
  localparam logic [1:0]  MODE_MS = 2'd1;

  typedef struct packed {
    logic          en;
    logic          pol;
    logic [1:0]    mode;
    logic [DW-1:0] range;
    logic [DW-1:0] duty;
  } ch_cfg_t;

  localparam ch_cfg_t CFG_RST = '{en: 1'b0, pol: 1'b0, mode: MODE_MS, range: '0, duty: '0};
endpackage

// File: rtl/pwm_sync_regs.sv
module pwm_sync_regs
  import pwm_sync_pkg::*;
#(
  parameter int unsigned NUM_CH = NUM_CH_DEF,
  parameter int unsigned AW     = AW_DEF
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [AW-1:0]            addr_i,
  input  logic                     we_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [DW-1:0]            rdata_o,
  input  logic [NUM_CH-1:0]        latch_i,
  output logic [NUM_CH-1:0]        pend_o,
  output ch_cfg_t [NUM_CH-1:0]     shadow_o
);
  localparam logic [AW-1:0] GLB_ADDR = AW'(GLB_OFS);

  logic                       glb_hit, glb_wr;
  logic [NUM_CH-1:0]          en_q, pend_q;
  logic [NUM_CH-1:0][DW-1:0]  rd_ch;

  assign glb_hit = (addr_i == GLB_ADDR);
  assign glb_wr  = we_i && glb_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      if (glb_wr) en_q <= wdata_i[NUM_CH-1:0];
      // a fresh request re-arms all channels, winning over same-cycle latches
      if (glb_wr && wdata_i[UPD_BIT]) pend_q <= '1;
      else                            pend_q <= pend_q & ~latch_i;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [AW-1:0] A_CTRL  = AW'(CH_BASE + CH_STRIDE * c + OFS_CTRL);
    localparam logic [AW-1:0] A_RANGE = AW'(CH_BASE + CH_STRIDE * c + OFS_RANGE);
    localparam logic [AW-1:0] A_PHASE = AW'(CH_BASE + CH_STRIDE * c + OFS_PHASE);
    localparam logic [AW-1:0] A_DUTY  = AW'(CH_BASE + CH_STRIDE * c + OFS_DUTY);

    logic [1:0]    mode_q;
    logic          pol_q, pop_q;
    logic [DW-1:0] range_q, duty_q, phase_q;
    logic [DW-1:0] rd_w;
    logic          hit_ctrl, hit_range, hit_phase, hit_duty;

    assign hit_ctrl  = (addr_i == A_CTRL);
    assign hit_range = (addr_i == A_RANGE);
    assign hit_phase = (addr_i == A_PHASE);
    assign hit_duty  = (addr_i == A_DUTY);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mode_q  <= MODE_MS;
        pol_q   <= 1'b0;
        pop_q   <= 1'b1;
        range_q <= '0;
        duty_q  <= '0;
        phase_q <= '0;
      end else if (we_i) begin
        if (hit_ctrl) begin
          mode_q <= wdata_i[1:0];
          pol_q  <= wdata_i[POL_BIT];
          pop_q  <= wdata_i[POP_BIT];
        end
        if (hit_range) range_q <= wdata_i;
        if (hit_phase) phase_q <= wdata_i;
        if (hit_duty)  duty_q  <= wdata_i;
      end
    end

    always_comb begin
      rd_w = '0;
      if (hit_ctrl) begin
        rd_w[1:0]     = mode_q;
        rd_w[POL_BIT] = pol_q;
        rd_w[POP_BIT] = pop_q;
      end else if (hit_range) begin
        rd_w = range_q;
      end else if (hit_phase) begin
        rd_w = phase_q;
      end else if (hit_duty) begin
        rd_w = duty_q;
      end
    end

    assign rd_ch[c]    = rd_w;
    assign shadow_o[c] = '{en: en_q[c], pol: pol_q, mode: mode_q, range: range_q, duty: duty_q};
  end

  always_comb begin
    rdata_o = '0;
    if (glb_hit) begin
      rdata_o[NUM_CH-1:0] = en_q;
      rdata_o[UPD_BIT]    = |pend_q;
    end
    for (int c = 0; c < NUM_CH; c++) rdata_o = rdata_o | rd_ch[c];
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/pwm_sync_chan.sv
module pwm_sync_chan
  import pwm_sync_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pend_i,
  input  ch_cfg_t       shadow_i,
  output logic          latch_o,
  output logic          pwm_o,
  output ch_cfg_t       act_o,
  output logic [DW-1:0] cnt_o
);
  ch_cfg_t       act_q;
  logic [DW-1:0] cnt_q;
  logic          wrap;

  // period of 0 or 1 wraps every cycle
  assign wrap    = act_q.en && ((act_q.range <= DW'(1)) || (cnt_q >= act_q.range - DW'(1)));
  assign latch_o = pend_i && (!act_q.en || wrap);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= CFG_RST;
      cnt_q <= '0;
    end else begin
      if (latch_o) act_q <= shadow_i;
      if (!act_q.en || wrap) cnt_q <= '0;
      else                   cnt_q <= cnt_q + DW'(1);
    end
  end

  always_comb begin
    pwm_o = act_q.pol;
    if (act_q.en && act_q.mode == MODE_MS) pwm_o = (cnt_q < act_q.duty) ^ act_q.pol;
  end

  assign act_o = act_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/pwm_sync_bank.sv
module pwm_sync_bank
  import pwm_sync_pkg::*;
#(
  parameter int unsigned NUM_CH = NUM_CH_DEF,
  parameter int unsigned AW     = AW_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              we_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [NUM_CH-1:0] pwm_o
);
  logic [NUM_CH-1:0]         pend, latch;
  ch_cfg_t [NUM_CH-1:0]      shadow, ch_act;
  logic [NUM_CH-1:0][DW-1:0] ch_cnt;

  pwm_sync_regs #(.NUM_CH(NUM_CH), .AW(AW)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .we_i     (we_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .latch_i  (latch),
    .pend_o   (pend),
    .shadow_o (shadow)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    pwm_sync_chan u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pend_i   (pend[c]),
      .shadow_i (shadow[c]),
      .latch_o  (latch[c]),
      .pwm_o    (pwm_o[c]),
      .act_o    (ch_act[c]),
      .cnt_o    (ch_cnt[c])
    );
  end
endmodule

// File: rtl/pwm_sync_bank_chk.sv
module pwm_sync_bank_chk
  import pwm_sync_pkg::*;
#(
  parameter int unsigned NUM_CH = NUM_CH_DEF
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NUM_CH-1:0]         pwm_i,
  input logic [NUM_CH-1:0]         pend_i,
  input logic [NUM_CH-1:0]         latch_i,
  input ch_cfg_t [NUM_CH-1:0]      act_i,
  input logic [NUM_CH-1:0][DW-1:0] cnt_i
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R9
    cnt_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !act_i[c].en |=> cnt_i[c] == '0);

    // R6
    cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act_i[c].en && act_i[c].range > DW'(1)) |-> cnt_i[c] < act_i[c].range);

    // R3
    act_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !latch_i[c] |=> ($stable(act_i[c].range) && $stable(act_i[c].duty) &&
                       $stable(act_i[c].en) && $stable(act_i[c].pol)));

    // R4
    pend_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(pend_i[c]) |-> $past(latch_i[c]));

    // R7
    full_duty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act_i[c].en && act_i[c].mode == MODE_MS && act_i[c].duty != '0 &&
       act_i[c].duty >= act_i[c].range) |-> pwm_i[c] == !act_i[c].pol);
  end
endmodule

bind pwm_sync_bank pwm_sync_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .pwm_i   (pwm_o),
  .pend_i  (pend),
  .latch_i (latch),
  .act_i   (ch_act),
  .cnt_i   (ch_cnt)
);

// File: tb/pwm_sync_bank_tb.sv
`timescale 1ns/1ps
module pwm_sync_bank_tb;
  localparam int N = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [6:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N-1:0] pwm_o;

  int n_chk = 0, n_err = 0, cycles = 0;
  bit run = 0, done = 0;
  string cur_req = "R1";

  always #2.5 clk_i = ~clk_i;

  pwm_sync_bank u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm_o)
  );

  // behavioural reference state
  logic [31:0] s_rng[N], s_duty[N], s_ph[N], a_rng[N], a_duty[N], m_cnt[N];
  logic [1:0]  s_mode[N], a_mode[N];
  bit          s_en[N], s_pol[N], s_pop[N], a_en[N], a_pol[N], m_pend[N], m_lat[N];

  function automatic int ofs(int c, int k);
    return 'h14 + 16 * c + k;
  endfunction

  function automatic logic [31:0] exp_read(int a);
    logic [31:0] v = '0;
    if (a == 0) begin
      for (int c = 0; c < N; c++) begin
        v[c] = s_en[c];
        if (m_pend[c]) v[31] = 1'b1;
      end
    end
    for (int c = 0; c < N; c++) begin
      if (a == ofs(c, 0)) begin v[1:0] = s_mode[c]; v[3] = s_pol[c]; v[8] = s_pop[c]; end
      if (a == ofs(c, 4))  v = s_rng[c];
      if (a == ofs(c, 8))  v = s_ph[c];
      if (a == ofs(c, 12)) v = s_duty[c];
    end
    return v;
  endfunction

  function automatic logic m_out(int c);
    if (a_en[c] && a_mode[c] == 2'd1) return (m_cnt[c] < a_duty[c]) ^ a_pol[c];
    return a_pol[c];
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < N; c++) begin
        s_en[c] = 0; s_pol[c] = 0; s_mode[c] = 2'd1; s_pop[c] = 1;
        s_rng[c] = 0; s_duty[c] = 0; s_ph[c] = 0;
        a_en[c] = 0; a_pol[c] = 0; a_mode[c] = 2'd1; a_rng[c] = 0; a_duty[c] = 0;
        m_cnt[c] = 0; m_pend[c] = 0;
      end
    end else begin
      for (int c = 0; c < N; c++) begin
        bit last;
        last = a_en[c] && (a_rng[c] <= 1 || m_cnt[c] >= a_rng[c] - 1);
        m_lat[c] = m_pend[c] && (!a_en[c] || last);
        if (!a_en[c] || last) m_cnt[c] = 0; else m_cnt[c] = m_cnt[c] + 1;
        if (m_lat[c]) begin
          a_en[c] = s_en[c]; a_pol[c] = s_pol[c]; a_mode[c] = s_mode[c];
          a_rng[c] = s_rng[c]; a_duty[c] = s_duty[c];
        end
      end
      for (int c = 0; c < N; c++) begin
        if (we && addr == 0 && wdata[31]) m_pend[c] = 1;
        else if (m_lat[c])                m_pend[c] = 0;
      end
      if (we) begin
        if (addr == 0) for (int c = 0; c < N; c++) s_en[c] = wdata[c];
        for (int c = 0; c < N; c++) begin
          if (addr == ofs(c, 0)) begin s_mode[c] = wdata[1:0]; s_pol[c] = wdata[3]; s_pop[c] = wdata[8]; end
          if (addr == ofs(c, 4))  s_rng[c] = wdata;
          if (addr == ofs(c, 8))  s_ph[c] = wdata;
          if (addr == ofs(c, 12)) s_duty[c] = wdata;
        end
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock output comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni && run && !done) begin
      logic [N-1:0] e;
      for (int c = 0; c < N; c++) e[c] = m_out(c);
      chk({cur_req, " pwm_o"}, 32'(pwm_o), 32'(e));
    end
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk_i); addr = 7'(a); we = 1'b1; wdata = d;
    @(negedge clk_i); we = 1'b0;
  endtask

  task automatic rd_now(int a, string req);
    addr = 7'(a); #1;
    chk(req, rdata, exp_read(a));
  endtask

  task automatic rd_exp(int a, logic [31:0] exp, string req);
    @(negedge clk_i); addr = 7'(a); #1;
    chk(req, rdata, exp);
  endtask

  task automatic count_high(int ch, int n, output int k);
    k = 0;
    repeat (n) begin @(negedge clk_i); #1; k += int'(pwm_o[ch]); end
  endtask

  initial begin
    int k, waited;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b1; run = 1;
    #1;
    // R1 reset state
    chk("R1 pwm", 32'(pwm_o), 32'h0);
    rd_exp(0, 32'h0, "R1 global");
    rd_exp(ofs(0, 0), 32'h101, "R1 ctrl0");
    rd_exp(ofs(3, 0), 32'h101, "R1 ctrl3");
    rd_exp(ofs(2, 4), 32'h0, "R1 range2");
    rd_exp(ofs(1, 12), 32'h0, "R1 duty1");

    // R2 map and field masks
    cur_req = "R2";
    wr(ofs(1, 4), 32'hDEADBEEF); rd_exp(ofs(1, 4), 32'hDEADBEEF, "R2 range1");
    wr(ofs(2, 0), 32'hFFFFFFFF); rd_exp(ofs(2, 0), 32'h0000010B, "R2 ctrl mask");
    wr('h04, 32'h55);            rd_exp('h04, 32'h0, "R2 unmapped 04");
    rd_exp('h64, 32'h0, "R2 unmapped 64");
    rd_exp('h15, 32'h0, "R2 unaligned 15");
    wr(ofs(2, 0), 32'h101); wr(ofs(1, 4), 32'h0);
    rd_exp(ofs(2, 0), 32'h101, "R2 ctrl restore");

    // R3 shadow only
    cur_req = "R3";
    wr(ofs(0, 4), 8); wr(ofs(0, 12), 3); wr(0, 32'h1);
    count_high(0, 20, k); chk("R3 no effect before commit", k, 0);
    rd_exp(0, 32'h1, "R3 enable shadow");

    // R5 commit flag with all channels parked
    cur_req = "R5";
    wr(0, 32'h80000001);
    rd_now(0, "R5 flag set");
    chk("R5 flag set explicit", rdata, 32'h80000001);
    rd_exp(0, 32'h00000001, "R5 flag cleared");

    // R6 mark/space counts
    cur_req = "R6";
    count_high(0, 8, k);  chk("R6 duty3 range8", k, 3);
    count_high(0, 16, k); chk("R6 two periods", k, 6);

    // R12 / R4 staggered channels
    cur_req = "R12";
    wr(ofs(1, 4), 5);  wr(ofs(1, 12), 2);
    wr(ofs(2, 4), 13); wr(ofs(2, 12), 6);
    wr(0, 32'h80000007);
    repeat (30) @(negedge clk_i);
    cur_req = "R4";
    wr(ofs(0, 12), 5); wr(ofs(1, 12), 4); wr(ofs(2, 12), 1);
    repeat (3) @(negedge clk_i);
    wr(0, 32'h80000007);
    waited = 0;
    rd_now(0, "R5 poll");
    while (rdata[31] && waited < 40) begin
      @(negedge clk_i); waited++;
      rd_now(0, "R5 poll");
    end
    chk("R4 commit within longest period", 32'(waited >= 1 && waited <= 13), 32'h1);
    count_high(1, 5, k);  chk("R12 ch1 duty4 range5", k, 4);
    count_high(2, 13, k); chk("R12 ch2 duty1 range13", k, 1);
    count_high(0, 8, k);  chk("R12 ch0 duty5 range8", k, 5);

    // R7 saturation
    cur_req = "R7";
    wr(ofs(3, 4), 10); wr(ofs(3, 12), 20); wr(0, 32'h8000000F);
    repeat (12) @(negedge clk_i);
    count_high(3, 25, k); chk("R7 duty over range", k, 25);
    wr(ofs(3, 12), 10); wr(0, 32'h8000000F);
    repeat (12) @(negedge clk_i);
    count_high(3, 20, k); chk("R7 duty equals range", k, 20);
    wr(ofs(3, 12), 0); wr(0, 32'h8000000F);
    repeat (12) @(negedge clk_i);
    count_high(3, 25, k); chk("R7 duty zero", k, 0);

    // R8 inversion, running and parked
    cur_req = "R8";
    wr(ofs(1, 0), 32'h109); wr(0, 32'h8000000F);
    repeat (8) @(negedge clk_i);
    count_high(1, 5, k); chk("R8 inverted ch1", k, 1);
    wr(ofs(2, 0), 32'h109); wr(0, 32'h8000000B);
    repeat (16) @(negedge clk_i);
    count_high(2, 10, k); chk("R8 R9 parked inverted level", k, 10);

    // R10 phase storage
    cur_req = "R10";
    for (int c = 0; c < N; c++) wr(ofs(c, 8), 32'h1234_0000 + 32'(c));
    rd_exp(ofs(2, 8), 32'h1234_0002, "R10 phase readback");
    count_high(0, 8, k); chk("R10 ch0 unchanged", k, 5);

    // R11 unsupported mode
    cur_req = "R11";
    wr(ofs(0, 0), 32'h102); wr(0, 32'h8000000B);
    repeat (10) @(negedge clk_i);
    count_high(0, 16, k); chk("R11 mode2 inactive", k, 0);

    // R9 restart from zero on enable (ch2 range 13 duty 1, uninverted)
    cur_req = "R9";
    wr(ofs(2, 0), 32'h101);
    wr(0, 32'h8000000F);
    @(negedge clk_i); #1;
    chk("R9 first cycle active", 32'(pwm_o[2]), 32'h1);
    count_high(2, 12, k); chk("R9 rest of first period", k, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule